// File: doc/BRIEF.md
# Address-Encoded NAND Command Sequencer

This block sits between a simple memory-mapped write port and the pins of a NAND flash device. It treats the write address as a control word, not a location. One bit chooses between a command access and a page-data access. Other fields carry up to two opcodes, an address-cycle count and an end-of-transfer flag for an external ECC engine. The write data carries either the address bytes or one 32-bit word of page data. Each accepted write is expanded into a string of byte cycles on the flash bus: command-latch cycles, address-latch cycles and plain data cycles. Each cycle has a fixed write-enable pulse.

Software issues one write per command and address sequence, or one write per data word. When an operation needs more than four address bytes, it follows the first write with a second write to the same offset. On the final word of a page, the same write can raise the ECC-last strobe and append a confirm opcode, so no separate command write is needed. The port's ready output stays low while cycles are still going out.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, ce_n and we_n are 1, cle, ale, ecc_last and io are 0, and wr_ready is 1.
- R2: A write with address bit 19 at 0 is a command access. Its first bus cycle sends address bits 10:3 (opcode 0) on io with cle at 1 and ale at 0.
- R3: In a command access, address bits 23:21 give a count N of address cycles. After opcode 0, min(N,4) cycles are sent with ale at 1 and cle at 0. They carry the write-data bytes starting at bits 7:0 and moving upward.
- R4: When N is above 4, after the fourth address cycle the block returns wr_ready to 1 and keeps ce_n at 0. It then waits for a write to the identical address, and sends N-4 further address cycles from that write's bytes, starting at bits 7:0.
- R5: While waiting for that continuation, a write to any other address is ignored: no bus cycle is sent and the block keeps waiting.
- R6: A write with address bit 19 at 1 is a data access. Its four data bytes are sent as four cycles, bits 7:0 first, with cle and ale both 0.
- R7: In a data access with address bit 10 at 1, ecc_last is 1 for exactly one clock: the last clock of the fourth byte cycle. ecc_last is never 1 otherwise.
- R8: When address bit 20 is 1, address bits 18:11 (opcode 1) are sent as one more cycle with cle at 1. This cycle follows the last data byte of a data access, or the last address cycle of a command access (after the continuation when N is above 4).
- R9: Each bus cycle holds we_n low for 2 clocks and then high for 2 clocks. io, cle and ale stay stable throughout the cycle, and cle and ale are never 1 together.
- R10: ce_n is 0 from the first cycle of an access until its last cycle has ended, and it returns to 1 afterwards unless a continuation is pending.
- R11: wr_ready falls in the clock after a write is accepted and stays 0 until all of that write's cycles are sent. A write presented while wr_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 24 | Write address carrying phase, opcodes, count and flags |
| wr_data | input | 32 | Address bytes or page data |
| wr_ready | output | 1 | Port can accept a write |
| ce_n | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Flash write enable, active low |
| io | output | 8 | Flash data bus |
| ecc_last | output | 1 | Strobe marking the last byte of an ECC-covered transfer |

## Verification
The in-module assertions check the cycle shape on every clock. They cover latch exclusivity, io and latch stability at the we_n rising edge, the minimum low width of we_n, and ecc_last appearing only between data cycles. They also check that wr_ready drops only after a write request, and that a pending continuation keeps chip enable asserted and ignores writes to other offsets. Only the bench scenarios can show that the byte order and the opcode placement match the address fields. The same holds for the split into four plus N-4 address cycles across two writes, the exact clock of the ecc_last pulse, and writes dropped while busy leaving no trace on the bus.

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int ADDR_W    = 24,
  parameter int LOW_CLKS  = 2,
  parameter int HIGH_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              wr_ready,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic [7:0]        io,
  output logic              ecc_last
);

  localparam int CYC       = LOW_CLKS + HIGH_CLKS;
  localparam int TW        = (CYC > 2) ? $clog2(CYC) : 1;
  localparam int DATA_BIT  = 19;
  localparam int VALID_BIT = 20;
  localparam int ECC_BIT   = 10;
  localparam int CNT_LSB   = 21;
  localparam int OP0_LSB   = 3;
  localparam int OP1_LSB   = 11;
  localparam logic [TW-1:0] LOW_T  = TW'(LOW_CLKS);
  localparam logic [TW-1:0] LAST_T = TW'(CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] cur_addr;
  logic [31:0]       cur_data;
  logic              seg;
  logic [2:0]        idx;
  logic [TW-1:0]     tick;

  logic       is_data, op1_v, ecc_flag, split;
  logic [2:0] n_addr, first_n, rest_n;
  logic [7:0] op0, op1;

  assign is_data  = cur_addr[DATA_BIT];
  assign op1_v    = cur_addr[VALID_BIT];
  assign ecc_flag = cur_addr[ECC_BIT];
  assign n_addr   = cur_addr[CNT_LSB +: 3];
  assign op0      = cur_addr[OP0_LSB +: 8];
  assign op1      = cur_addr[OP1_LSB +: 8];
  assign split    = n_addr > 3'd4;
  assign first_n  = split ? 3'd4 : n_addr;
  assign rest_n   = n_addr - 3'd4;

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] k);
    return w[8*k +: 8];
  endfunction

  logic       s_cle, s_ale;
  logic [7:0] s_byte;
  logic [2:0] total;
  logic [2:0] idx_m1;

  assign idx_m1 = idx - 3'd1;

  always_comb begin
    s_cle  = 1'b0;
    s_ale  = 1'b0;
    s_byte = 8'h00;
    if (is_data) begin
      total = 3'd4 + {2'b00, op1_v};
      if (idx < 3'd4) s_byte = byte_of(cur_data, idx[1:0]);
      else begin
        s_cle  = 1'b1;
        s_byte = op1;
      end
    end else if (!seg) begin
      total = 3'd1 + first_n + {2'b00, op1_v & ~split};
      if (idx == 3'd0) begin
        s_cle  = 1'b1;
        s_byte = op0;
      end else if (idx <= first_n) begin
        s_ale  = 1'b1;
        s_byte = byte_of(cur_data, idx_m1[1:0]);
      end else begin
        s_cle  = 1'b1;
        s_byte = op1;
      end
    end else begin
      total = rest_n + {2'b00, op1_v};
      if (idx < rest_n) begin
        s_ale  = 1'b1;
        s_byte = byte_of(cur_data, idx[1:0]);
      end else begin
        s_cle  = 1'b1;
        s_byte = op1;
      end
    end
  end

  logic busy, last_slot, accept;

  assign busy      = (st == S_SEND);
  assign last_slot = (idx == total - 3'd1);
  assign accept    = wr_en && ((st == S_IDLE) || (st == S_WAIT && wr_addr == cur_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      cur_data <= '0;
      seg      <= 1'b0;
      idx      <= '0;
      tick     <= '0;
    end else begin
      case (st)
        S_SEND: begin
          if (tick == LAST_T) begin
            tick <= '0;
            if (last_slot) st <= (!is_data && !seg && split) ? S_WAIT : S_IDLE;
            else idx <= idx + 3'd1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          if (accept) begin
            cur_addr <= wr_addr;
            cur_data <= wr_data;
            seg      <= (st == S_WAIT);
            idx      <= '0;
            tick     <= '0;
            st       <= S_SEND;
          end
        end
      endcase
    end
  end

  assign wr_ready = !busy;
  assign ce_n     = (st == S_IDLE);
  assign we_n     = !(busy && tick < LOW_T);
  assign cle      = busy && s_cle;
  assign ale      = busy && s_ale;
  assign io       = busy ? s_byte : 8'h00;
  assign ecc_last = busy && is_data && ecc_flag && idx == 3'd3 && tick == LAST_T;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R9
  AST_IO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(io) && $stable(cle) && $stable(ale))); // R9
  generate
    if (LOW_CLKS >= 2) begin : g_low_chk
      AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(we_n) |=> !we_n); // R9
    end
  endgenerate
  AST_ECC_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_last |-> (!cle && !ale && we_n && !ce_n)); // R7
  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_ready) |-> $past(wr_en)); // R11
  AST_WAIT_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && wr_en && wr_addr != cur_addr) |=> (st == S_WAIT)); // R5
  AST_WAIT_HOLD_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (!ce_n && we_n && wr_ready)); // R4

endmodule

// File: tb/sim_nand_addr_seq.sv
module sim_nand_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [23:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_ready, ce_n, cle, ale, we_n, ecc_last;
  logic [7:0]  io;

  always #10 clk = ~clk;

  nand_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .io(io),
    .ecc_last(ecc_last)
  );

  logic [7:0] cap_b [0:255];
  logic       cap_c [0:255];
  logic       cap_a [0:255];
  logic       cap_ce[0:255];
  int cap_n = 0, ecc_cnt = 0, ecc_at = 0;
  int bad_low = 0, bad_high = 0, bad_stab = 0;
  int low_run = 0, hi_run = 0;
  logic prev_we = 1'b1;
  logic [7:0] low_io = 8'h00;
  logic low_c = 1'b0, low_a = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) begin
        if (prev_we) begin
          if (hi_run != 0 && hi_run != 2) bad_high++;
          low_run = 0;
          low_io = io; low_c = cle; low_a = ale;
        end
        low_run++;
        if (io != low_io || cle != low_c || ale != low_a) bad_stab++;
      end else begin
        if (!prev_we) begin
          if (low_run != 2) bad_low++;
          if (io != low_io || cle != low_c || ale != low_a) bad_stab++;
          cap_b[cap_n & 255] = io;
          cap_c[cap_n & 255] = cle;
          cap_a[cap_n & 255] = ale;
          cap_ce[cap_n & 255] = ce_n;
          cap_n++;
          hi_run = 0;
        end
        hi_run++;
      end
      if (wr_ready) hi_run = 0;
      if (ecc_last) begin ecc_cnt++; ecc_at = cap_n; end
      prev_we = we_n;
    end
  end

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [7:0] eb [0:15];
  logic       ec [0:15];
  logic       ea [0:15];
  int en;

  task automatic push(input logic c, input logic a, input logic [7:0] b);
    eb[en] = b; ec[en] = c; ea[en] = a; en++;
  endtask

  function automatic logic [23:0] cmd_addr(input logic [2:0] n, input logic [7:0] o0,
                                           input logic v, input logic [7:0] o1);
    return {n, v, 1'b0, o1, o0, 3'b000};
  endfunction

  function automatic logic [23:0] dat_addr(input logic ecc, input logic v, input logic [7:0] o1);
    return {3'b000, v, 1'b1, o1, ecc, 10'h000};
  endfunction

  task automatic send(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(!wr_ready && !ce_n, "R11", "ready low and ce low after accept", {wr_ready, ce_n}, 0);
  endtask

  task automatic wait_done();
    while (!wr_ready) @(negedge clk);
  endtask

  task automatic compare(input int base, input bit is_cmd);
    chk(cap_n - base == en, "R10", "cycle count", cap_n - base, en);
    for (int i = 0; i < en; i++) begin
      int k;
      string r;
      k = (base + i) & 255;
      if (ec[i] && is_cmd && i == 0) r = "R2";
      else if (ec[i]) r = "R8";
      else if (ea[i]) r = "R3";
      else r = "R6";
      chk({cap_ce[k], cap_c[k], cap_a[k], cap_b[k]} == {1'b0, ec[i], ea[i], eb[i]}, r,
          "bus cycle {ce,cle,ale,io}", {cap_ce[k], cap_c[k], cap_a[k], cap_b[k]},
          {1'b0, ec[i], ea[i], eb[i]});
    end
  endtask

  task automatic run_cmd(input logic [2:0] n, input logic [7:0] o0, input logic v,
                         input logic [7:0] o1, input logic [63:0] ab, input bit stray);
    int base, e0;
    logic [23:0] a;
    base = cap_n; e0 = ecc_cnt; en = 0;
    a = cmd_addr(n, o0, v, o1);
    push(1'b1, 1'b0, o0);
    for (int i = 0; i < n; i++) push(1'b0, 1'b1, ab[8*i +: 8]);
    if (v) push(1'b1, 1'b0, o1);
    send(a, ab[31:0]);
    if (n > 3'd4) begin
      wait_done();
      chk(!ce_n, "R4", "ce held low while continuation pending", ce_n, 0);
      chk(cap_n - base == 5, "R4", "cycles before continuation", cap_n - base, 5);
      if (stray) begin
        wr_en = 1'b1; wr_addr = a ^ 24'h000008; wr_data = $urandom;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (10) @(negedge clk);
        chk(cap_n - base == 5 && wr_ready && !ce_n, "R5", "stray write during wait",
            cap_n - base, 5);
      end
      send(a, ab[63:32]);
    end
    wait_done();
    compare(base, 1'b1);
    chk(ce_n, "R10", "ce released after access", ce_n, 1);
    chk(ecc_cnt == e0, "R7", "no ecc strobe in command access", ecc_cnt - e0, 0);
  endtask

  task automatic run_data(input logic [31:0] w, input logic ecc, input logic v,
                          input logic [7:0] o1, input bit poke);
    int base, e0;
    base = cap_n; e0 = ecc_cnt; en = 0;
    for (int i = 0; i < 4; i++) push(1'b0, 1'b0, w[8*i +: 8]);
    if (v) push(1'b1, 1'b0, o1);
    send(dat_addr(ecc, v, o1), w);
    if (poke) begin
      wr_en = 1'b1; wr_addr = cmd_addr(3'd2, 8'hEE, 1'b1, 8'hDD); wr_data = 32'hDEADBEEF;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b0;
    end
    wait_done();
    compare(base, 1'b0);
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(cap_n - base == en && ce_n, "R11", "write while busy ignored", cap_n - base, en);
    end
    chk(ecc_cnt - e0 == int'(ecc), "R7", "ecc strobe count", ecc_cnt - e0, int'(ecc));
    if (ecc) chk(ecc_at - base == 4, "R7", "ecc strobe position", ecc_at - base, 4);
    chk(ce_n, "R10", "ce released after data word", ce_n, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && !cle && !ale && !ecc_last && io == 8'h00 && wr_ready, "R1",
        "reset state", {ce_n, we_n, cle, ale, ecc_last, wr_ready}, 6'b110001);

    run_cmd(3'd0, 8'hFF, 1'b0, 8'h00, 64'h0, 1'b0);
    run_cmd(3'd3, 8'h00, 1'b1, 8'h30, 64'h00000000_00C2B1A0, 1'b0);
    run_cmd(3'd4, 8'h80, 1'b0, 8'h00, 64'h00000000_44332211, 1'b0);
    run_cmd(3'd5, 8'h00, 1'b1, 8'h30, 64'h00000055_44332211, 1'b1);
    run_cmd(3'd7, 8'h60, 1'b1, 8'hD0, 64'h00776655_44332211, 1'b0);
    run_data(32'hA1B2C3D4, 1'b0, 1'b0, 8'h00, 1'b1);
    run_data(32'h0F1E2D3C, 1'b1, 1'b0, 8'h00, 1'b0);
    run_data(32'h12345678, 1'b1, 1'b1, 8'h10, 1'b0);
    run_data(32'h9ABCDEF0, 1'b0, 1'b1, 8'h15, 1'b0);

    for (int t = 0; t < 40; t++) begin
      if ($urandom % 2) begin
        run_cmd(3'($urandom % 8), 8'($urandom), 1'($urandom), 8'($urandom),
                {$urandom, $urandom}, 1'($urandom));
      end else begin
        run_data($urandom, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
      end
    end

    chk(bad_low == 0, "R9", "we_n low width violations", bad_low, 0);
    chk(bad_high == 0, "R9", "we_n high width violations", bad_high, 0);
    chk(bad_stab == 0, "R9", "bus changes inside a cycle", bad_stab, 0);
    finish_run();
  end
endmodule